// File: doc/BRIEF.md
# Dual-Personality Parallel Host Register Port

This block is the host-facing register access port of a line-interface device. A CPU reaches a small internal register file through it, with either Intel-style strobes (read, write, address-latch-enable) or Motorola-style strobes (data strobe, read/not-write, address strobe). The address reaches the block in one of two ways. It can arrive on separate address pins. It can also be multiplexed onto the 8-bit data bus and captured on the rising edge of the address-latch input. Three static select pins choose the personality and the addressing scheme. A fourth pin turns the whole parallel port off.

All bus pins are sampled on the core clock, and every strobe edge is detected on those sampled copies. Location 0 returns the live level of the condition inputs. Location 1 holds change flags: a flag is set whenever its condition input toggles, and a read of location 1 clears the flags. Location 2 is the interrupt mask. The remaining locations are plain control storage. The open-drain interrupt pin is modelled as an enable that asserts while any unmasked change flag is set.

Top module: `hbi_host_port`

## Requirements
- R1: After hardware reset (rst_n low), every writable location reads 0x00, all change flags are 0, irq_oe is 0 and bus_oe is 0.
- R2: In Intel mode with separate address pins (sel_moto=0, sel_direct=1), a write stores bus_i at the location given by addr_i on the rising edge of the write strobe (dir) while cs_n is low. A read with cs_n and strb_n low returns that byte.
- R3: In Motorola mode (sel_moto=1), a write takes effect on the rising edge of the data strobe (strb_n) while cs_n is low and dir (read/not-write) is 0. A read returns data while strb_n is low and dir is 1.
- R4: With the multiplexed bus (sel_direct=0), the rising edge of ale captures the low 5 bits of bus_i as the address, and addr_i is ignored. This holds for both personalities.
- R5: While cs_n is high, strobe activity writes nothing and bus_oe stays 0.
- R6: bus_oe is 1 only while cs_n is low and the read strobe is active (Intel: strb_n low; Motorola: strb_n low with dir high). A write strobe alone never enables the bus.
- R7: While sel_serial is 1, the port performs no reads and no writes, and bus_oe stays 0.
- R8: Location 0 returns the live condition inputs and location 1 returns the change flags. Writes to locations 0 and 1 have no effect. Locations 2 to 31 are read/write.
- R9: A change flag bit is set when its condition bit toggles in either direction. The end of a read of location 1 (the read strobe rising while cs_n is low) clears all flags. A toggle in the same cycle as the clear wins.
- R10: irq_oe is 1 exactly when some change flag is set whose bit in location 2 (the mask, 1 = enabled) is also 1. It asserts within 3 clock cycles of the condition toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all bus pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sel_serial | input | 1 | 1 disables the parallel port |
| sel_direct | input | 1 | 1 = separate address pins, 0 = multiplexed bus |
| sel_moto | input | 1 | 1 = Motorola strobes, 0 = Intel strobes |
| cs_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Intel read strobe / Motorola data strobe, active low |
| dir | input | 1 | Intel write strobe (active low) / Motorola read-not-write |
| ale | input | 1 | Address latch enable / address strobe, rising edge |
| addr_i | input | ADDR_W | Register address in non-multiplexed mode |
| bus_i | input | DATA_W | Data in; also the address in multiplexed mode |
| bus_o | output | DATA_W | Read data, 0 when not driven |
| bus_oe | output | 1 | Data bus output enable |
| cond_i | input | DATA_W | Condition inputs watched for change |
| irq_oe | output | 1 | Pull-down enable of the open-drain interrupt |

## Verification
A wrong strobe decode or a wrong address latch shows up at the next read-back as a wrong byte on bus_o, or as bus_oe set where it must stay 0. Every write in the bench is therefore read back under each personality and each addressing scheme. A change flag stuck or lost shows on irq_oe within three cycles of the condition toggle, and on the next read of location 1. A clear that fails shows on the second read, which must return zero.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // sampled copies of the control pins
  typedef struct packed {
    logic cs_n;
    logic strb_n;
    logic dir;
    logic ale;
  } pins_t;

  // decoded bus events for one clock cycle
  typedef struct packed {
    logic wr_pulse;
    logic rd_active;
    logic rd_end;
    logic ale_rise;
  } bus_evt_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, strb_n: 1'b1, dir: 1'b1, ale: 1'b0};
endpackage

// File: rtl/hbi_pin_sample.sv
module hbi_pin_sample
  import hbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pins_t             pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] bus_i,
  output pins_t             cur_o,
  output pins_t             prev_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] bus_o
);
  pins_t             cur_q, prev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] bus_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= PINS_IDLE;
      prev_q <= PINS_IDLE;
      addr_q <= '0;
      bus_q  <= '0;
    end else begin
      cur_q  <= pins_i;
      prev_q <= cur_q;
      addr_q <= addr_i;
      bus_q  <= bus_i;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
  assign addr_o = addr_q;
  assign bus_o  = bus_q;
endmodule

// File: rtl/hbi_strobe_dec.sv
module hbi_strobe_dec
  import hbi_pkg::*;
(
  input  logic     enable_i,
  input  logic     moto_i,
  input  pins_t    cur_i,
  input  pins_t    prev_i,
  output bus_evt_t evt_o
);
  logic cs_ok, strb_rise, dir_rise;

  always_comb begin
    cs_ok     = enable_i & ~cur_i.cs_n;
    strb_rise = cur_i.strb_n & ~prev_i.strb_n;
    dir_rise  = cur_i.dir & ~prev_i.dir;
    evt_o     = '0;
    if (moto_i) begin
      evt_o.wr_pulse  = cs_ok & strb_rise & ~cur_i.dir;
      evt_o.rd_active = cs_ok & ~cur_i.strb_n & cur_i.dir;
      evt_o.rd_end    = cs_ok & strb_rise & cur_i.dir;
    end else begin
      evt_o.wr_pulse  = cs_ok & dir_rise;
      evt_o.rd_active = cs_ok & ~cur_i.strb_n;
      evt_o.rd_end    = cs_ok & strb_rise;
    end
    evt_o.ale_rise = enable_i & cur_i.ale & ~prev_i.ale;
  end
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              direct_i,
  input  logic              ale_rise_i,
  input  logic [ADDR_W-1:0] bus_low_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] lat_q, lat_d;
  logic              lat_en;

  always_comb begin
    lat_en = ale_rise_i & ~direct_i;
    lat_d  = lat_en ? bus_low_i : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign addr_o = direct_i ? addr_pins_i : lat_q;
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse_i,
  input  logic              rd_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cond_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              chg_any_o,
  output logic              irq_o
);
  localparam int unsigned NREG     = 1 << ADDR_W;
  localparam int unsigned LOC_LIVE = 0;
  localparam int unsigned LOC_FLAG = 1;
  localparam int unsigned LOC_MASK = 2;
  localparam int unsigned FIRST_RW = LOC_MASK;

  logic [DATA_W-1:0] store [NREG];
  logic [DATA_W-1:0] cond_s_q, cond_p_q, flag_q, flag_d, chg;
  logic              clr;

  for (genvar i = 0; i < NREG; i++) begin : g_loc
    if (i < FIRST_RW) begin : g_ro
      assign store[i] = '0;
    end else begin : g_rw
      logic we;
      assign we = wr_pulse_i && (addr_i == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  store[i] <= '0;
        else if (we) store[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    chg    = cond_s_q ^ cond_p_q;
    clr    = rd_end_i && (addr_i == ADDR_W'(LOC_FLAG));
    flag_d = (flag_q & ~{DATA_W{clr}}) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_s_q <= '0;
      cond_p_q <= '0;
      flag_q   <= '0;
    end else begin
      cond_s_q <= cond_i;
      cond_p_q <= cond_s_q;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    if (addr_i == ADDR_W'(LOC_LIVE))      rdata_o = cond_s_q;
    else if (addr_i == ADDR_W'(LOC_FLAG)) rdata_o = flag_q;
    else                                  rdata_o = store[addr_i];
  end

  assign flags_o   = flag_q;
  assign chg_any_o = |chg;
  assign irq_o     = |(flag_q & store[LOC_MASK]);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_serial,
  input  logic              sel_direct,
  input  logic              sel_moto,
  input  logic              cs_n,
  input  logic              strb_n,
  input  logic              dir,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] cond_i,
  output logic              irq_oe
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  pins_t             pins, cur, prev;
  bus_evt_t          evt;
  logic [ADDR_W-1:0] addr_s, addr_eff;
  logic [DATA_W-1:0] bus_s, rdata, flags;
  logic              chg_any;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign pins = '{cs_n: cs_n, strb_n: strb_n, dir: dir, ale: ale};

  hbi_pin_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk(clk), .rst_n(rst_sync_n), .pins_i(pins), .addr_i(addr_i), .bus_i(bus_i),
    .cur_o(cur), .prev_o(prev), .addr_o(addr_s), .bus_o(bus_s)
  );

  hbi_strobe_dec u_dec (
    .enable_i(~sel_serial), .moto_i(sel_moto), .cur_i(cur), .prev_i(prev), .evt_o(evt)
  );

  hbi_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
    .clk(clk), .rst_n(rst_sync_n), .direct_i(sel_direct), .ale_rise_i(evt.ale_rise),
    .bus_low_i(bus_s[ADDR_W-1:0]), .addr_pins_i(addr_s), .addr_o(addr_eff)
  );

  hbi_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_pulse_i(evt.wr_pulse), .rd_end_i(evt.rd_end),
    .addr_i(addr_eff), .wdata_i(bus_s), .cond_i(cond_i), .rdata_o(rdata),
    .flags_o(flags), .chg_any_o(chg_any), .irq_o(irq_oe)
  );

  assign bus_oe = evt.rd_active;
  assign bus_o  = evt.rd_active ? rdata : '0;
endmodule

// File: rtl/hbi_host_port_chk.sv
module hbi_host_port_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_serial,
  input logic              cs_s_n,
  input logic              bus_oe,
  input logic              wr_pulse,
  input logic              rd_end,
  input logic              chg_any,
  input logic              irq_oe,
  input logic [ADDR_W-1:0] addr_eff,
  input logic [DATA_W-1:0] flags
);
  p_oe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !cs_s_n);

  p_no_write_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s_n |-> !wr_pulse);

  p_port_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_serial |-> (!bus_oe && !wr_pulse));

  p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> ($past(chg_any) || $past(wr_pulse)));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && addr_eff == ADDR_W'(1) && !chg_any) |=> (flags == '0));
endmodule

bind hbi_host_port hbi_host_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sel_serial(sel_serial), .cs_s_n(cur.cs_n),
  .bus_oe(bus_oe), .wr_pulse(evt.wr_pulse), .rd_end(evt.rd_end), .chg_any(chg_any),
  .irq_oe(irq_oe), .addr_eff(addr_eff), .flags(flags)
);

// File: tb/tb_hbi_host_port.sv
module tb_hbi_host_port;
  logic       clk = 1'b0;
  logic       rst_n, sel_serial, sel_direct, sel_moto;
  logic       cs_n, strb_n, dir, ale;
  logic [4:0] addr;
  logic [7:0] bus_i, bus_o, cond;
  logic       bus_oe, irq_oe;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  hbi_host_port dut (
    .clk(clk), .rst_n(rst_n), .sel_serial(sel_serial), .sel_direct(sel_direct),
    .sel_moto(sel_moto), .cs_n(cs_n), .strb_n(strb_n), .dir(dir), .ale(ale),
    .addr_i(addr), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .cond_i(cond), .irq_oe(irq_oe)
  );

  typedef struct packed {
    logic       moto;
    logic       direct;
    logic [4:0] loc;
    logic [7:0] wdata;
    logic [7:0] expd;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 5'd3,  8'hA5, 8'hA5},
    '{1'b1, 1'b1, 5'd4,  8'h3C, 8'h3C},
    '{1'b0, 1'b0, 5'd31, 8'h81, 8'h81},
    '{1'b1, 1'b0, 5'd17, 8'h7E, 8'h7E},
    '{1'b0, 1'b1, 5'd0,  8'hFF, 8'h00},
    '{1'b1, 1'b0, 5'd2,  8'h00, 8'h00},
    '{1'b0, 1'b0, 5'd10, 8'h55, 8'h55},
    '{1'b1, 1'b1, 5'd30, 8'hC3, 8'hC3},
    '{1'b0, 1'b1, 5'd1,  8'hFF, 8'h00},
    '{1'b1, 1'b0, 5'd3,  8'h0F, 8'h0F}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_addr(input logic direct, input logic [4:0] a, input logic [4:0] pin_a);
    sel_direct = direct;
    if (direct) begin
      addr = a;
    end else begin
      addr  = pin_a;
      bus_i = {3'b000, a};
      ale   = 1'b1;
      cyc(2);
      ale   = 1'b0;
      cyc(1);
    end
  endtask

  task automatic bus_write(input logic moto, input logic direct, input logic [4:0] a,
                           input logic [7:0] d, input logic [4:0] pin_a, input logic sel);
    sel_moto = moto;
    cyc(1);
    put_addr(direct, a, pin_a);
    bus_i = d;
    cs_n  = ~sel;
    if (moto) begin
      dir = 1'b0; cyc(2);
      strb_n = 1'b0; cyc(2);
      strb_n = 1'b1; cyc(2);
      dir = 1'b1;
    end else begin
      cyc(2);
      dir = 1'b0; cyc(2);
      dir = 1'b1; cyc(2);
    end
    cs_n = 1'b1;
    cyc(2);
  endtask

  task automatic bus_read(input logic moto, input logic direct, input logic [4:0] a,
                          input logic [4:0] pin_a, output logic [7:0] d, output logic oe);
    sel_moto = moto;
    cyc(1);
    put_addr(direct, a, pin_a);
    cs_n = 1'b0;
    dir  = 1'b1;
    cyc(1);
    strb_n = 1'b0;
    cyc(3);
    d  = bus_o;
    oe = bus_oe;
    strb_n = 1'b1;
    cyc(2);
    cs_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    rst_n = 1'b0; sel_serial = 1'b0; sel_direct = 1'b1; sel_moto = 1'b0;
    cs_n = 1'b1; strb_n = 1'b1; dir = 1'b1; ale = 1'b0;
    addr = '0; bus_i = '0; cond = '0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);

    // R1: reset state
    chk("R1 irq", {7'd0, irq_oe}, 8'h00);
    chk("R1 oe idle", {7'd0, bus_oe}, 8'h00);
    bus_read(1'b0, 1'b1, 5'd31, 5'd0, rd, oe);
    chk("R1 loc31", rd, 8'h00);

    // vector table: write then read back under each mode
    for (int i = 0; i < 10; i++) begin
      string tag;
      if (VEC[i].loc < 5'd2)  tag = "R8";
      else if (!VEC[i].direct) tag = "R4";
      else if (VEC[i].moto)    tag = "R3";
      else                     tag = "R2";
      bus_write(VEC[i].moto, VEC[i].direct, VEC[i].loc, VEC[i].wdata, 5'd0, 1'b1);
      bus_read(VEC[i].moto, VEC[i].direct, VEC[i].loc, 5'd0, rd, oe);
      chk(tag, rd, VEC[i].expd);
      chk("R6 oe on read", {7'd0, oe}, 8'h01);
    end

    // R4: address pins ignored in multiplexed mode
    bus_write(1'b0, 1'b0, 5'd9, 8'hE7, 5'd7, 1'b1);
    bus_read(1'b0, 1'b1, 5'd9, 5'd0, rd, oe);
    chk("R4 latched loc", rd, 8'hE7);
    bus_read(1'b0, 1'b1, 5'd7, 5'd0, rd, oe);
    chk("R4 pin loc untouched", rd, 8'h00);
    bus_read(1'b1, 1'b0, 5'd9, 5'd7, rd, oe);
    chk("R4 moto mux read", rd, 8'hE7);

    // R5: deselected write and read
    bus_write(1'b0, 1'b1, 5'd4, 8'h11, 5'd0, 1'b0);
    bus_read(1'b0, 1'b1, 5'd4, 5'd0, rd, oe);
    chk("R5 write ignored", rd, 8'h3C);
    sel_moto = 1'b0; cs_n = 1'b1; strb_n = 1'b0; cyc(3);
    chk("R5 oe deselected", {7'd0, bus_oe}, 8'h00);
    strb_n = 1'b1; cyc(2);

    // R6: write strobe alone never drives the bus
    sel_moto = 1'b0; cs_n = 1'b0; dir = 1'b0; cyc(3);
    chk("R6 intel wr low", {7'd0, bus_oe}, 8'h00);
    cs_n = 1'b1; cyc(1); dir = 1'b1; cyc(2);
    sel_moto = 1'b1; dir = 1'b0; cs_n = 1'b0; cyc(1); strb_n = 1'b0; cyc(3);
    chk("R6 moto write phase", {7'd0, bus_oe}, 8'h00);
    cs_n = 1'b1; cyc(1); strb_n = 1'b1; cyc(1); dir = 1'b1; cyc(2);

    // R7: port disabled
    sel_serial = 1'b1;
    bus_write(1'b0, 1'b1, 5'd3, 8'h99, 5'd0, 1'b1);
    bus_read(1'b0, 1'b1, 5'd3, 5'd0, rd, oe);
    chk("R7 oe off", {7'd0, oe}, 8'h00);
    sel_serial = 1'b0;
    bus_read(1'b0, 1'b1, 5'd3, 5'd0, rd, oe);
    chk("R7 write ignored", rd, 8'h0F);

    // R8: live conditions
    cond = 8'h05; cyc(4);
    bus_read(1'b0, 1'b1, 5'd0, 5'd0, rd, oe);
    chk("R8 live", rd, 8'h05);

    // R9: change flags and clear on read
    bus_read(1'b0, 1'b1, 5'd1, 5'd0, rd, oe);
    chk("R9 flags", rd, 8'h05);
    bus_read(1'b1, 1'b1, 5'd1, 5'd0, rd, oe);
    chk("R9 cleared", rd, 8'h00);

    // R10: masked and unmasked interrupt
    bus_write(1'b0, 1'b1, 5'd2, 8'h01, 5'd0, 1'b1);
    chk("R10 no flag", {7'd0, irq_oe}, 8'h00);
    cond = 8'h01; cyc(4);
    chk("R10 masked", {7'd0, irq_oe}, 8'h00);
    bus_read(1'b0, 1'b1, 5'd1, 5'd0, rd, oe);
    chk("R9 falling edge", rd, 8'h04);
    cond = 8'h00; cyc(3);
    chk("R10 unmasked", {7'd0, irq_oe}, 8'h01);
    bus_read(1'b0, 1'b1, 5'd1, 5'd0, rd, oe);
    chk("R9 bit0", rd, 8'h01);
    chk("R10 cleared", {7'd0, irq_oe}, 8'h00);
    cond = 8'h02; cyc(4);
    bus_read(1'b0, 1'b0, 5'd1, 5'd0, rd, oe);
    chk("R9 rising edge", rd, 8'h02);
    cond = 8'h00; cyc(4);

    // R1: reset in mid-run clears storage, mask and flags
    rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(5);
    chk("R1 irq after reset", {7'd0, irq_oe}, 8'h00);
    bus_read(1'b0, 1'b1, 5'd3, 5'd0, rd, oe);
    chk("R1 loc3", rd, 8'h00);
    bus_read(1'b0, 1'b1, 5'd2, 5'd0, rd, oe);
    chk("R1 mask", rd, 8'h00);
    bus_read(1'b0, 1'b1, 5'd1, 5'd0, rd, oe);
    chk("R1 flags", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule